// File: doc/BRIEF.md
# Filtered Event Counter Bank

This block holds a set of wide event counters, each steered by its own control word. Every cycle the surrounding logic presents a vector of event strobes together with the attributes of the transaction behind those events: a partition identifier, a monitoring-group bit, stream and prefetch flags, a subsource code and an opcode. Each counter picks one strobe through an 8-bit select code. Any mix of attribute filters can narrow the selection, and each filter has its own enable bit and compare value. A counter increments only when its strobe fires and every enabled filter agrees with the attributes.

A small register port writes control words, preloads counters and reads any counter. Select code 0 parks a counter. Code 0xFF counts clock cycles and ignores the filters. Codes 1 to EVT_W pick strobe `evt_vec[code-1]`. All other codes count nothing. Counters wrap silently, and a software preload wins over an increment in the same cycle.

Top module: `evctr_bank`

## Requirements
- R1: A synchronous active-high reset clears every counter to 0 and every control word to 0 (select 0), so no counter moves after reset until it is programmed.
- R2: A counter whose select code is 0 never increments, whatever the strobes and attributes are.
- R3: A counter whose select code is 0xFF increments by one on every clock edge and ignores all attribute filters, even filters that are enabled and do not match.
- R4: A select code k with 1 <= k <= EVT_W counts on each edge where `evt_vec[k-1]` is 1 and all enabled filters match. A control write takes effect for events in the cycle after the write edge.
- R5: Control bit 8 enables the partition filter. The event then counts only if `at_partid` equals control bits [18:10].
- R6: Bit 9 enables the group filter against bit 27. Bit 35 enables the stream filter against bit 36. Bit 37 enables the prefetch filter against bit 38. Select code sits in bits [7:0].
- R7: Bit 39 enables the subsource filter against bits [41:40]. Bit 42 enables the opcode filter against bits [49:43].
- R8: A filter whose enable bit is 0 has no effect, whatever its compare value is. With several filters enabled, all of them must match.
- R9: A counter write (`wr_en`=1, `wr_target`=1) loads `wr_data` into counter `wr_idx` at that edge and overrides any increment due in the same cycle. A control write uses `wr_target`=0.
- R10: A counter holding 2^64-1 that increments becomes 0, with no other effect.
- R11: Select codes from EVT_W+1 to 0xFE count nothing.
- R12: `rd_count` shows counter `rd_idx` combinationally. Reading has no side effect, and a counter with no write and no qualified event holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_vec | input | EVT_W | Per-cycle event strobes; select k counts bit k-1 |
| at_partid | input | 9 | Partition identifier of the current transaction |
| at_group | input | 1 | Monitoring-group bit of the current transaction |
| at_stream | input | 1 | Stream flag of the current transaction |
| at_prefetch | input | 1 | Prefetch flag of the current transaction |
| at_subsrc | input | 2 | Subsource code of the current transaction |
| at_opcode | input | 7 | Opcode of the current transaction |
| wr_en | input | 1 | Register write strobe |
| wr_target | input | 1 | 0 = control word, 1 = counter value |
| wr_idx | input | log2(NUM_CTR) | Counter slot written |
| wr_data | input | 64 | Write data (control word or counter preload) |
| rd_idx | input | log2(NUM_CTR) | Counter slot read |
| rd_count | output | CNT_W | Current value of the counter addressed by rd_idx |

## Verification
Two pairs of actions can land on the same edge. A software preload can meet a qualified increment, and a control rewrite can meet events that the old control word still qualifies. The bench forces both pairs on purpose: it preloads a counter that is running in cycle mode, and it rewrites control words while strobes are asserted. It also does both at random during a long mixed run. The bench's own model applies the load-wins rule and the old-control-this-edge rule, and it compares every counter through the read port after every edge.

// File: rtl/evctr_pkg.sv
`timescale 1ns/1ps
package evctr_pkg;

    localparam int CTL_W  = 64;
    localparam int SEL_W  = 8;
    localparam int PART_W = 9;
    localparam int SUB_W  = 2;
    localparam int OPC_W  = 7;

    localparam logic [SEL_W-1:0] SEL_NONE  = 8'h00;
    localparam logic [SEL_W-1:0] SEL_CYCLE = 8'hFF;

    // control word bit positions (software encodes against these)
    localparam int B_SEL     = 0;
    localparam int B_PART_EN = 8;
    localparam int B_GRP_EN  = 9;
    localparam int B_PART    = 10;
    localparam int B_GRP     = 27;
    localparam int B_STR_EN  = 35;
    localparam int B_STR     = 36;
    localparam int B_PF_EN   = 37;
    localparam int B_PF      = 38;
    localparam int B_SUB_EN  = 39;
    localparam int B_SUB     = 40;
    localparam int B_OPC_EN  = 42;
    localparam int B_OPC     = 43;

    typedef struct packed {
        logic [OPC_W-1:0]  opcode;
        logic [SUB_W-1:0]  subsrc;
        logic              prefetch;
        logic              stream;
        logic              group;
        logic [PART_W-1:0] partid;
    } txn_attr_t;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic              part_en;
        logic [PART_W-1:0] part_val;
        logic              grp_en;
        logic              grp_val;
        logic              str_en;
        logic              str_val;
        logic              pf_en;
        logic              pf_val;
        logic              sub_en;
        logic [SUB_W-1:0]  sub_val;
        logic              opc_en;
        logic [OPC_W-1:0]  opc_val;
    } ctr_ctl_t;

    localparam ctr_ctl_t CTL_RESET = '0;

endpackage

// File: rtl/evctr_qual.sv
`timescale 1ns/1ps
module evctr_qual
    import evctr_pkg::*;
#(
    parameter int EVT_W = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  ctr_ctl_t         ctl,
    input  logic [EVT_W-1:0] evt_vec,
    input  txn_attr_t        attr,
    output logic             hit
);

    logic ev_on;
    logic attr_ok;

    // select code k (1..EVT_W) picks strobe k-1
    always_comb begin
        ev_on = 1'b0;
        for (int k = 1; k <= EVT_W; k++) begin
            if (ctl.sel == SEL_W'(k)) ev_on = evt_vec[k-1];
        end
    end

    always_comb begin
        attr_ok = (!ctl.part_en || (attr.partid   == ctl.part_val))
               && (!ctl.grp_en  || (attr.group    == ctl.grp_val))
               && (!ctl.str_en  || (attr.stream   == ctl.str_val))
               && (!ctl.pf_en   || (attr.prefetch == ctl.pf_val))
               && (!ctl.sub_en  || (attr.subsrc   == ctl.sub_val))
               && (!ctl.opc_en  || (attr.opcode   == ctl.opc_val));
    end

    assign hit = (ctl.sel == SEL_CYCLE) || (ev_on && attr_ok);

    AST_SEL_NONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (ctl.sel == SEL_NONE) |-> !hit); // R2
    AST_CYCLE_ALWAYS: assert property (@(posedge clk) disable iff (rst)
        (ctl.sel == SEL_CYCLE) |-> hit); // R3
    AST_PART_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (ctl.sel != SEL_CYCLE && ctl.part_en && attr.partid != ctl.part_val) |-> !hit); // R5
    AST_OPC_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (ctl.sel != SEL_CYCLE && ctl.opc_en && attr.opcode != ctl.opc_val) |-> !hit); // R7
    AST_UNKNOWN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (ctl.sel > SEL_W'(EVT_W) && ctl.sel != SEL_CYCLE) |-> !hit); // R11

endmodule

// File: rtl/evctr_cnt.sv
`timescale 1ns/1ps
module evctr_cnt #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (load) cnt <= load_val;
        else if (inc)  cnt <= cnt + CNT_W'(1);
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (cnt == '0)); // R1
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(load_val))); // R9
    AST_STEP_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!load && inc) |=> (cnt == $past(cnt) + CNT_W'(1))); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!load && !inc) |=> $stable(cnt)); // R12

endmodule

// File: rtl/evctr_bank.sv
`timescale 1ns/1ps
module evctr_bank
    import evctr_pkg::*;
#(
    parameter int NUM_CTR = 8,
    parameter int CNT_W   = 64,
    parameter int EVT_W   = 48,
    localparam int IDX_W  = $clog2(NUM_CTR)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [EVT_W-1:0]    evt_vec,
    input  logic [PART_W-1:0]   at_partid,
    input  logic                at_group,
    input  logic                at_stream,
    input  logic                at_prefetch,
    input  logic [SUB_W-1:0]    at_subsrc,
    input  logic [OPC_W-1:0]    at_opcode,
    input  logic                wr_en,
    input  logic                wr_target,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [CTL_W-1:0]    wr_data,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [CNT_W-1:0]    rd_count
);

    txn_attr_t        attr;
    ctr_ctl_t         ctl_in;
    logic [CNT_W-1:0] cnt_q [NUM_CTR];

    assign attr = '{opcode: at_opcode, subsrc: at_subsrc, prefetch: at_prefetch,
                    stream: at_stream, group: at_group, partid: at_partid};

    // decode the written word into the stored control fields
    always_comb begin
        ctl_in          = CTL_RESET;
        ctl_in.sel      = wr_data[B_SEL +: SEL_W];
        ctl_in.part_en  = wr_data[B_PART_EN];
        ctl_in.part_val = wr_data[B_PART +: PART_W];
        ctl_in.grp_en   = wr_data[B_GRP_EN];
        ctl_in.grp_val  = wr_data[B_GRP];
        ctl_in.str_en   = wr_data[B_STR_EN];
        ctl_in.str_val  = wr_data[B_STR];
        ctl_in.pf_en    = wr_data[B_PF_EN];
        ctl_in.pf_val   = wr_data[B_PF];
        ctl_in.sub_en   = wr_data[B_SUB_EN];
        ctl_in.sub_val  = wr_data[B_SUB +: SUB_W];
        ctl_in.opc_en   = wr_data[B_OPC_EN];
        ctl_in.opc_val  = wr_data[B_OPC +: OPC_W];
    end

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_slot
        ctr_ctl_t ctl_q;
        logic     hit;
        logic     ctl_we;
        logic     cnt_we;

        assign ctl_we = wr_en && !wr_target && (wr_idx == IDX_W'(i));
        assign cnt_we = wr_en &&  wr_target && (wr_idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst)         ctl_q <= CTL_RESET;
            else if (ctl_we) ctl_q <= ctl_in;
        end

        evctr_qual #(.EVT_W(EVT_W)) u_qual (
            .clk     (clk),
            .rst     (rst),
            .ctl     (ctl_q),
            .evt_vec (evt_vec),
            .attr    (attr),
            .hit     (hit)
        );

        evctr_cnt #(.CNT_W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .load     (cnt_we),
            .load_val (wr_data[CNT_W-1:0]),
            .inc      (hit),
            .cnt      (cnt_q[i])
        );
    end

    assign rd_count = cnt_q[rd_idx];

endmodule

// File: tb/sim_evctr_bank.sv
`timescale 1ns/1ps
module sim_evctr_bank;

    localparam int NC = 8;
    localparam int EW = 48;

    logic        clk = 1'b0;
    logic        rst;
    logic [EW-1:0] evt_vec;
    logic [8:0]  at_partid;
    logic        at_group, at_stream, at_prefetch;
    logic [1:0]  at_subsrc;
    logic [6:0]  at_opcode;
    logic        wr_en, wr_target;
    logic [2:0]  wr_idx, rd_idx;
    logic [63:0] wr_data;
    logic [63:0] rd_count;

    evctr_bank u0 (
        .clk(clk), .rst(rst), .evt_vec(evt_vec), .at_partid(at_partid),
        .at_group(at_group), .at_stream(at_stream), .at_prefetch(at_prefetch),
        .at_subsrc(at_subsrc), .at_opcode(at_opcode), .wr_en(wr_en),
        .wr_target(wr_target), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_count(rd_count)
    );

    always #2.5 clk = ~clk;

    logic [63:0] m_ctl [NC];
    logic [63:0] m_cnt [NC];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string cur_req = "R1";

    // behavioural view of the qualification rules (R2..R8, R11)
    function automatic bit ref_hit(logic [63:0] w);
        int s = int'(w[7:0]);
        if (s == 255) return 1'b1;
        if (s == 0 || s > EW) return 1'b0;
        if (!evt_vec[s-1]) return 1'b0;
        if (w[8]  && w[18:10] != at_partid)   return 1'b0;
        if (w[9]  && w[27]    != at_group)    return 1'b0;
        if (w[35] && w[36]    != at_stream)   return 1'b0;
        if (w[37] && w[38]    != at_prefetch) return 1'b0;
        if (w[39] && w[41:40] != at_subsrc)   return 1'b0;
        if (w[42] && w[49:43] != at_opcode)   return 1'b0;
        return 1'b1;
    endfunction

    task automatic cyc();
        logic [63:0] nc [NC];
        logic [63:0] nk [NC];
        for (int i = 0; i < NC; i++) begin
            nc[i] = m_ctl[i];
            nk[i] = m_cnt[i];
            if (rst) begin
                nc[i] = '0; nk[i] = '0;
            end else begin
                if (wr_en && wr_target && wr_idx == 3'(i)) nk[i] = wr_data;
                else if (ref_hit(m_ctl[i]))                nk[i] = m_cnt[i] + 64'd1;
                if (wr_en && !wr_target && wr_idx == 3'(i)) nc[i] = wr_data;
            end
        end
        @(posedge clk);
        for (int i = 0; i < NC; i++) begin
            m_ctl[i] = nc[i];
            m_cnt[i] = nk[i];
        end
        #1;
        for (int i = 0; i < NC; i++) begin
            rd_idx = 3'(i);
            #0.1;
            n_chk++;
            if (rd_count !== m_cnt[i]) begin
                n_bad++;
                $display("FAIL %s ctr%0d got %h exp %h at %0t", cur_req, i, rd_count, m_cnt[i], $time);
            end
        end
    endtask

    task automatic wr_ctl(int i, logic [63:0] w);
        wr_en = 1; wr_target = 0; wr_idx = 3'(i); wr_data = w;
        cyc();
        wr_en = 0;
    endtask

    task automatic wr_cnt(int i, logic [63:0] v);
        wr_en = 1; wr_target = 1; wr_idx = 3'(i); wr_data = v;
        cyc();
        wr_en = 0;
    endtask

    task automatic idle_attrs();
        at_partid = '0; at_group = 0; at_stream = 0; at_prefetch = 0;
        at_subsrc = '0; at_opcode = '0;
    endtask

    function automatic logic [63:0] sel_word(int s);
        return 64'(s[7:0]);
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired during %s", cur_req);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NC; i++) begin m_ctl[i] = 'x; m_cnt[i] = 'x; end
        rst = 1; evt_vec = '1; idle_attrs();
        wr_en = 0; wr_target = 0; wr_idx = 0; wr_data = '0; rd_idx = 0;

        // R1: reset clears all counters and controls
        cur_req = "R1";
        cyc(); cyc();
        rst = 0;
        cyc(); cyc();

        // R2: select 0 with every strobe high stays still
        cur_req = "R2";
        repeat (4) cyc();

        // R3: cycle mode, and cycle mode with a failing partition filter
        cur_req = "R3";
        wr_ctl(0, sel_word(255));
        wr_ctl(2, sel_word(255) | (64'd1 << 8) | (64'h1FF << 10));
        at_partid = 9'h003;
        repeat (5) cyc();

        // R4: plain event selection, strobe toggled
        cur_req = "R4";
        wr_ctl(1, sel_word(5));
        wr_ctl(6, sel_word(48));
        for (int c = 0; c < 8; c++) begin
            evt_vec = '0;
            evt_vec[4]  = c[0];
            evt_vec[47] = c[1];
            cyc();
        end

        // R4: control rewrite on an edge where events are live
        evt_vec = '1;
        wr_ctl(1, sel_word(0));
        cyc();

        // R5: partition filter
        cur_req = "R5";
        wr_ctl(3, sel_word(7) | (64'd1 << 8) | (64'h1A5 << 10));
        for (int c = 0; c < 6; c++) begin
            at_partid = (c % 2 == 0) ? 9'h1A5 : 9'h0A5;
            cyc();
        end

        // R6: group, stream, prefetch filters
        cur_req = "R6";
        wr_ctl(4, sel_word(7) | (64'd1 << 9) | (64'd1 << 27) | (64'd1 << 35));
        wr_ctl(5, sel_word(7) | (64'd1 << 37) | (64'd1 << 38));
        for (int c = 0; c < 8; c++) begin
            at_group = c[0]; at_stream = c[1]; at_prefetch = c[2];
            cyc();
        end

        // R7: subsource and opcode filters
        cur_req = "R7";
        wr_ctl(6, sel_word(7) | (64'd1 << 39) | (64'd2 << 40));
        wr_ctl(7, sel_word(7) | (64'd1 << 42) | (64'h55 << 43));
        for (int c = 0; c < 8; c++) begin
            at_subsrc = 2'(c);
            at_opcode = c[0] ? 7'h55 : 7'h54;
            cyc();
        end

        // R8: all compare values junk but enables clear, then all enabled and matching
        cur_req = "R8";
        wr_ctl(3, sel_word(7) | (64'h1FF << 10) | (64'd1 << 27) | (64'd1 << 36)
                  | (64'd1 << 38) | (64'd3 << 40) | (64'h7F << 43));
        idle_attrs();
        repeat (3) cyc();
        wr_ctl(4, sel_word(7) | (64'd1 << 8) | (64'd1 << 9) | (64'd1 << 35) | (64'd1 << 37)
                  | (64'd1 << 39) | (64'd1 << 42));
        repeat (3) cyc();
        at_opcode = 7'h01;
        repeat (2) cyc();
        idle_attrs();

        // R11: unknown selects
        cur_req = "R11";
        evt_vec = '1;
        wr_ctl(1, sel_word(49));
        wr_ctl(5, sel_word(200));
        wr_ctl(6, sel_word(254));
        repeat (4) cyc();

        // R9: preload of a counter that is counting every cycle
        cur_req = "R9";
        wr_cnt(0, 64'h0123_4567_89AB_CDEF);
        cyc();
        wr_cnt(1, 64'h0000_0000_0000_0042);
        cyc();

        // R10: wrap at the top of the range
        cur_req = "R10";
        wr_cnt(0, 64'hFFFF_FFFF_FFFF_FFFF);
        cyc(); cyc();
        wr_cnt(2, 64'hFFFF_FFFF_FFFF_FFFE);
        cyc(); cyc(); cyc();

        // R12: long mixed run, random reads every cycle
        cur_req = "R12";
        for (int c = 0; c < 3000; c++) begin
            evt_vec     = {$urandom, $urandom};
            at_partid   = 9'($urandom % 2);
            at_group    = 1'($urandom);
            at_stream   = 1'($urandom);
            at_prefetch = 1'($urandom);
            at_subsrc   = 2'($urandom);
            at_opcode   = 7'($urandom % 2);
            if ($urandom % 6 == 0) begin
                logic [63:0] w = {$urandom, $urandom};
                int pick = int'($urandom % 4);
                w[7:0]   = (pick == 0) ? 8'hFF : (pick == 1) ? 8'(1 + $urandom % EW)
                         : (pick == 2) ? 8'(49 + $urandom % 200) : 8'h00;
                w[18:10] = 9'($urandom % 2);
                w[49:43] = 7'($urandom % 2);
                wr_en = 1; wr_target = 0; wr_idx = 3'($urandom); wr_data = w;
            end else if ($urandom % 10 == 0) begin
                wr_en = 1; wr_target = 1; wr_idx = 3'($urandom);
                wr_data = ($urandom % 2 == 0) ? {$urandom, $urandom} : (64'hFFFF_FFFF_FFFF_FFFD);
            end else begin
                wr_en = 0;
            end
            cyc();
            wr_en = 0;
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule